// File: doc/BRIEF.md
# Dual-Convention Byte-Serial Stack Engine

This block runs 8-bit and 16-bit push and pop operations against a 16-bit stack pointer that it holds internally. It reaches memory through a byte-wide synchronous port, one byte access per clock. A mode input selects how the pointer is read. In the post-decrement convention, the pointer names the next free byte. In the pre-decrement convention, it names the most recently written byte. Each convention has its own rules for the access address and for the pointer update, for both byte and word sizes.

A request is taken only while the engine is idle. A small sequencer then issues the byte accesses. For a word, these are two accesses in consecutive cycles, lower address first, and the word is stored big-endian. When the operation finishes, the engine raises a one-cycle completion pulse. The pointer takes its new value in that same cycle, and a popped value is presented alongside the pulse. The pointer can also be preset from outside while the engine is idle.

Top module: `stack_engine`

## Requirements
- R1: After reset, `sp` equals the parameter RESET_SP (0 by default), `ready` is 1, and both `done` and `mem_en` are 0.
- R2: Post-decrement mode (`mode_last_used`=0), push. A byte push writes at SP, and SP becomes SP-1. A word push writes the high byte at SP-1 and the low byte at SP, and SP becomes SP-2.
- R3: Post-decrement mode, pop. A byte pop reads SP+1, and SP becomes SP+1. A word pop reads the high byte at SP+1 and the low byte at SP+2, and SP becomes SP+2.
- R4: Pre-decrement mode (`mode_last_used`=1), push. A byte push writes at SP-1, and SP becomes SP-1. A word push writes the high byte at SP-2 and the low byte at SP-1, and SP becomes SP-2.
- R5: Pre-decrement mode, pop. A byte pop reads SP, and SP becomes SP+1. A word pop reads the high byte at SP and the low byte at SP+1, and SP becomes SP+2.
- R6: Every access is a single byte with `mem_en`=1, where `mem_we`=1 means write. Read data on `mem_rdata` is valid in the cycle after the read. A word takes two consecutive access cycles, and the second address is the first plus 1.
- R7: Call the cycle that begins at the accepting clock edge cycle 1. Then `done` is high for exactly one cycle, in cycle 2 for a byte push, cycle 3 for a word push or a byte pop, and cycle 4 for a word pop.
- R8: `sp` changes to its new value in the cycle where `done` is high and not before. In that cycle, a pop presents its data on `rd_data`. A byte pop zero-extends into bits 15:8.
- R9: `ready` is 1 only while idle. A `req_valid` seen while busy is ignored and has no effect on memory or on `sp`.
- R10: `sp_load`, taken while idle and with `req_valid` low, sets `sp` to `sp_load_val` at the next edge. If `req_valid` is high in the same idle cycle, the request is taken and the load is dropped.
- R11: All address and pointer arithmetic wraps modulo 2^16.
- R12: The engine is ready again in the `done` cycle. A request taken there uses the updated `sp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation request |
| req_push | input | 1 | 1 = push, 0 = pop |
| req_word | input | 1 | 1 = 16-bit, 0 = 8-bit |
| mode_last_used | input | 1 | 0 = post-decrement convention, 1 = pre-decrement convention |
| req_wdata | input | 16 | Push value (byte push uses bits 7:0) |
| sp_load | input | 1 | Preset the stack pointer |
| sp_load_val | input | 16 | Preset value |
| ready | output | 1 | Idle, request can be taken |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Popped value, valid with done |
| sp | output | 16 | Current stack pointer |
| mem_en | output | 1 | Byte access strobe |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid one cycle after the read |

## Verification
Two events can land in the same cycle: the completion pulse of one operation and the acceptance of the next. The testbench provokes this by chaining a push straight into a pop in the `done` cycle. It judges the result by whether the pop addresses memory from the freshly updated pointer and returns the pushed value, which must hold in both conventions. The other collision is a pointer preset arriving in the same idle cycle as a request. The testbench checks that the preset is dropped, so the pointer ends at the value the operation computes from the old pointer. A full sweep over both modes, all four operations and pointer values at both wrap boundaries checks the addresses, the byte order, the latency and the final pointer.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC0 = 2'd1,
    ST_ACC1 = 2'd2,
    ST_TAIL = 2'd3
  } seq_t;

  typedef struct packed {
    logic push;
    logic word;
    logic last_used;
  } op_t;

endpackage

// File: rtl/stk_addr.sv
module stk_addr #(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0]   sp_cur,
  input  stk_pkg::op_t    op,
  output logic [AW-1:0]   first_addr,
  output logic [AW-1:0]   next_sp
);
  // Step size of the operation, in bytes
  function automatic logic [AW-1:0] f_step(input logic word);
    return word ? AW'(2) : AW'(1);
  endfunction

  // Address of the first byte touched (the high byte of a word)
  function automatic logic [AW-1:0] f_first(input logic [AW-1:0] s, input stk_pkg::op_t o);
    logic [AW-1:0] a;
    if (o.push) begin
      if (o.last_used) a = s - f_step(o.word);
      else             a = o.word ? s - AW'(1) : s;
    end else begin
      a = o.last_used ? s : s + AW'(1);
    end
    return a;
  endfunction

  // Pointer value after the operation
  function automatic logic [AW-1:0] f_next(input logic [AW-1:0] s, input stk_pkg::op_t o);
    return o.push ? s - f_step(o.word) : s + f_step(o.word);
  endfunction

  assign first_addr = f_first(sp_cur, op);
  assign next_sp    = f_next(sp_cur, op);

endmodule

// File: rtl/stk_rdbuf.sv
module stk_rdbuf #(
  parameter int unsigned BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            cap_hi,
  input  logic            cap_lo,
  input  logic [BW-1:0]   rdata,
  output logic [2*BW-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= '0;
    end else if (clr) begin
      value <= '0;
    end else begin
      if (cap_hi) value[2*BW-1:BW] <= rdata;
      if (cap_lo) value[BW-1:0]    <= rdata;
    end
  end
endmodule

// File: rtl/stk_seq.sv
module stk_seq #(
  parameter int unsigned AW = 16,
  parameter int unsigned BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  stk_pkg::op_t    op_in,
  input  logic [AW-1:0]   first_in,
  input  logic [AW-1:0]   nsp_in,
  input  logic [2*BW-1:0] wdata_in,
  output logic            ready,
  output logic            mem_en,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [BW-1:0]   mem_wdata,
  output logic            cap_hi,
  output logic            cap_lo,
  output logic            finish,
  output logic            done,
  output logic [AW-1:0]   nsp_q
);
  import stk_pkg::*;

  seq_t            state_q, state_d;
  op_t             op_q;
  logic [AW-1:0]   addr_q;
  logic [2*BW-1:0] wd_q;

  always_comb begin
    state_d   = state_q;
    ready     = 1'b0;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    cap_hi    = 1'b0;
    cap_lo    = 1'b0;
    finish    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        ready = 1'b1;
        if (start) state_d = ST_ACC0;
      end
      ST_ACC0: begin
        mem_en    = 1'b1;
        mem_we    = op_q.push;
        mem_addr  = addr_q;
        if (op_q.push)
          mem_wdata = op_q.word ? wd_q[2*BW-1:BW] : wd_q[BW-1:0];
        finish    = op_q.push && !op_q.word;
        if (finish)         state_d = ST_IDLE;
        else if (op_q.word) state_d = ST_ACC1;
        else                state_d = ST_TAIL;
      end
      ST_ACC1: begin
        mem_en    = 1'b1;
        mem_we    = op_q.push;
        mem_addr  = addr_q + AW'(1);
        if (op_q.push) mem_wdata = wd_q[BW-1:0];
        cap_hi    = !op_q.push;
        finish    = op_q.push;
        state_d   = op_q.push ? ST_IDLE : ST_TAIL;
      end
      default: begin
        cap_lo  = 1'b1;
        finish  = 1'b1;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      addr_q  <= '0;
      wd_q    <= '0;
      nsp_q   <= '0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= finish;
      if (start && ready) begin
        op_q   <= op_in;
        addr_q <= first_in;
        wd_q   <= wdata_in;
        nsp_q  <= nsp_in;
      end
    end
  end

  // R7: completion is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: no memory traffic while idle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !mem_en);
  // R6: second byte of a word follows the first by one address
  a_r6_second_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACC1) |-> (mem_en && $past(mem_en) && mem_addr == $past(mem_addr) + AW'(1)));
  // R12: engine is idle again during the completion cycle
  a_r12_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready);

endmodule

// File: rtl/stack_engine.sv
module stack_engine #(
  parameter int unsigned AW       = 16,
  parameter int unsigned BW       = 8,
  parameter logic [15:0] RESET_SP = 16'h0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_push,
  input  logic          req_word,
  input  logic          mode_last_used,
  input  logic [15:0]   req_wdata,
  input  logic          sp_load,
  input  logic [15:0]   sp_load_val,
  output logic          ready,
  output logic          done,
  output logic [15:0]   rd_data,
  output logic [15:0]   sp,
  output logic          mem_en,
  output logic          mem_we,
  output logic [15:0]   mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata
);
  import stk_pkg::*;

  localparam int unsigned DW = 2 * BW;

  op_t           op_req;
  logic [AW-1:0] sp_q, first_addr, next_sp, nsp_q;
  logic          start, finish, cap_hi, cap_lo, load_take;
  logic [DW-1:0] rd_word;

  assign op_req    = '{push: req_push, word: req_word, last_used: mode_last_used};
  assign start     = req_valid && ready;
  assign load_take = sp_load && ready && !req_valid;

  stk_addr #(.AW(AW)) u_addr (
    .sp_cur     (sp_q),
    .op         (op_req),
    .first_addr (first_addr),
    .next_sp    (next_sp)
  );

  stk_seq #(.AW(AW), .BW(BW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op_in     (op_req),
    .first_in  (first_addr),
    .nsp_in    (next_sp),
    .wdata_in  (DW'(req_wdata)),
    .ready     (ready),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .cap_hi    (cap_hi),
    .cap_lo    (cap_lo),
    .finish    (finish),
    .done      (done),
    .nsp_q     (nsp_q)
  );

  stk_rdbuf #(.BW(BW)) u_rdbuf (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (start),
    .cap_hi (cap_hi),
    .cap_lo (cap_lo),
    .rdata  (mem_rdata),
    .value  (rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         sp_q <= AW'(RESET_SP);
    else if (finish)    sp_q <= nsp_q;
    else if (load_take) sp_q <= sp_load_val;
  end

  assign sp      = sp_q;
  assign rd_data = rd_word;

  // R8 / R10: pointer moves only with completion or after a taken preset
  a_r8_sp_moves_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp) |-> (done || $past(load_take)));
  // R9: nothing starts while an operation is in flight
  a_r9_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && req_valid) |=> !(done && $past(mem_en) && $stable(sp)));

endmodule

// File: tb/test_stack_engine.sv
module test_stack_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_push = 0, req_word = 0, mode_last_used = 0;
  logic [15:0] req_wdata = 0;
  logic sp_load = 0;
  logic [15:0] sp_load_val = 0;
  logic ready, done, mem_en, mem_we;
  logic [15:0] rd_data, sp, mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = 8'h00;

  int total = 0, bad = 0;
  logic [7:0] mem [logic [15:0]];
  logic [15:0] log_addr [0:7];
  int log_n = 0;

  always #10ns clk = ~clk;

  stack_engine i_stack_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_push(req_push),
    .req_word(req_word), .mode_last_used(mode_last_used), .req_wdata(req_wdata),
    .sp_load(sp_load), .sp_load_val(sp_load_val), .ready(ready), .done(done),
    .rd_data(rd_data), .sp(sp), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] rdm(input logic [15:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (mem_en) begin
      if (log_n < 8) log_addr[log_n] = mem_addr;
      log_n = log_n + 1;
      if (mem_we) mem[mem_addr] = mem_wdata;
      else        mem_rdata <= rdm(mem_addr);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge where done is seen
  task automatic run_op(input logic push, input logic word, input logic lu,
                        input logic [15:0] wd, input bit noise, output int lat,
                        output bit early_sp);
    logic [15:0] sp0;
    sp0 = sp;
    early_sp = 0;
    req_valid = 1; req_push = push; req_word = word; mode_last_used = lu; req_wdata = wd;
    lat = 0;
    log_n = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      lat++;
      if (noise) begin
        req_valid = 1; req_push = ~push; req_word = ~word; req_wdata = ~wd;
      end else begin
        req_valid = 0;
      end
      if (!done && sp !== sp0) early_sp = 1;
    end while (!done && lat < 12);
    req_valid = 0;
  endtask

  task automatic load_sp(input logic [15:0] v);
    sp_load = 1; sp_load_val = v;
    @(posedge clk); @(negedge clk);
    sp_load = 0;
  endtask

  initial begin
    #(20ns * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] sps [0:7];
    int lat; bit early;
    sps[0] = 16'h0000; sps[1] = 16'h0001; sps[2] = 16'h0002; sps[3] = 16'h7FFF;
    sps[4] = 16'h8000; sps[5] = 16'hFFFE; sps[6] = 16'hFFFF; sps[7] = 16'h1234;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sp", sp, 16'h0000);
    chk("R1 ready", ready, 1);
    chk("R1 done", done, 0);
    chk("R1 mem_en", mem_en, 0);
    rst_n = 1;
    @(negedge clk);

    for (int m = 0; m < 2; m++) begin
      for (int o = 0; o < 4; o++) begin
        for (int k = 0; k < 8; k++) begin
          logic push, word;
          logic [15:0] s0, a0, a1, exp_sp, wd;
          int step, off, exp_lat;
          string rq;
          push = o[1]; word = o[0];
          s0 = sps[k];
          step = word ? 2 : 1;
          if (push) begin
            off = m ? -step : (word ? -1 : 0);
            exp_sp = s0 - 16'(step);
            exp_lat = word ? 3 : 2;
          end else begin
            off = m ? 0 : 1;
            exp_sp = s0 + 16'(step);
            exp_lat = word ? 4 : 3;
          end
          a0 = s0 + 16'(off);
          a1 = a0 + 16'd1;
          rq = push ? (m ? "R4" : "R2") : (m ? "R5" : "R3");
          wd = {8'hA0 ^ 8'(k), 8'h5C ^ 8'(o * 16 + m)};
          // R10 preset
          load_sp(s0);
          chk("R10 preset", sp, s0);
          if (push) begin
            mem[a0] = 8'hEE; mem[a1] = 8'hEE;
          end else begin
            mem[a0] = wd[15:8]; mem[a1] = wd[7:0];
          end
          run_op(push, word, 1'(m), wd, k[0], lat, early);
          chk({rq, " sp R11"}, sp, exp_sp);
          chk("R7 latency", lat, exp_lat);
          chk("R8 sp not early", early, 0);
          chk("R6 access count", log_n, word ? 2 : 1);
          chk({rq, " first addr"}, log_addr[0], a0);
          if (word) chk("R6 second addr", log_addr[1], a1);
          if (push) begin
            if (word) begin
              chk({rq, " R6 hi byte"}, rdm(a0), wd[15:8]);
              chk({rq, " R6 lo byte"}, rdm(a1), wd[7:0]);
            end else begin
              chk({rq, " byte"}, rdm(a0), wd[7:0]);
              chk("R9 untouched", rdm(a1), 8'hEE);
            end
          end else begin
            chk({rq, " R8 data"}, rd_data, word ? wd : {8'h00, wd[15:8]});
          end
          @(negedge clk);
          chk("R7 pulse ends", done, 0);
          chk("R9 busy noise", sp, exp_sp);
        end
      end
    end

    // R10 conflict: request wins over preset
    load_sp(16'h0400);
    sp_load = 1; sp_load_val = 16'h7777;
    run_op(1, 1, 0, 16'hBEEF, 0, lat, early);
    sp_load = 0;
    chk("R10 request wins", sp, 16'h03FE);
    chk("R10 data at 03FF", rdm(16'h03FF), 8'hBE);

    // R12 back-to-back: push then pop accepted in the done cycle
    for (int m = 0; m < 2; m++) begin
      load_sp(16'h0200);
      run_op(1, 1, 1'(m), 16'hC3D4, 0, lat, early);
      run_op(0, 1, 1'(m), 16'h0000, 0, lat, early);
      chk("R12 chained latency", lat, 4);
      chk("R12 chained data", rd_data, 16'hC3D4);
      chk("R12 chained sp", sp, 16'h0200);
      @(negedge clk);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule